// File: doc/BRIEF.md
# USB High-Speed Handshake Monitor

This block watches the line state of a USB 2.0 link without driving it, and reports two flags: that a device is attached, and that the link has moved into High-speed operation. The analog front end has already decoded the differential pair into single-ended-zero, J and K indications. Squelch, pull-up detection, disconnect detection, compliance-fixture detection and test-packet detection also arrive from that front end as clean, synchronous digital inputs.

Attachment is tracked by a small link-presence machine. The High-speed flag can be reached in two ways. The normal way runs through a chirp tracker. It waits for a bus reset, then needs exactly one chirp J followed by one chirp K, each with a duration inside a timing window, and then squelch. The compliance way needs a test fixture to be detected from the unconnected state, followed by a test packet. All durations are counted in cycles of a free-running clock. Its frequency is a parameter, and the microsecond limits are converted to cycle counts at elaboration.

Top module: `usb_hs_link_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `conn_det` and `hs_en` read 0, whatever the other inputs are. After release the block sits in the unconnected state, so a handshake that was under way before reset never raises either flag.
- R2: From the unconnected state, `pullup_det` sampled high at a clock edge raises `conn_det` right after that edge. A pull-up seen while already connected changes nothing.
- R3: `disconnect` sampled high clears `conn_det` and `hs_en` right after that edge and returns the block to the unconnected state. `hs_en` is never high while `conn_det` is low.
- R4: A bus reset is single-ended-zero held for at least RESET_MIN_US worth of clock cycles (3 cycles in the bench setting). A shorter single-ended-zero does not start a handshake.
- R5: After a bus reset, a chirp J whose length is inside the window, followed directly by a chirp K whose length is inside the window, and then squelch, raises `hs_en`. The window is CHIRP_MIN_US to CHIRP_MAX_US, inclusive at both ends (18 to 128 cycles in the bench setting).
- R6: A chirp J or chirp K shorter than the lower limit or longer than the upper limit is rejected. In that case `hs_en` stays low even if squelch follows.
- R7: Any other sequence sends the chirp tracker back to waiting for a bus reset. This covers a J with no K after it, and a second chirp pair after a rejected one. Only a new bus reset can lead to success.
- R8: A bus reset clears `hs_en`. The flag stays clear, even if squelch is seen, until a fresh successful handshake.
- R9: `fixture_det` sampled high in the unconnected state raises `conn_det`, and takes priority over `pullup_det` sampled at the same edge. A `test_pkt_seen` pulse sampled after that raises `hs_en`.
- R10: `fixture_det` has no effect while a device is already connected. `test_pkt_seen` has no effect unless a fixture was detected from the unconnected state.
- R11: Squelch has no effect on `hs_en` unless a valid chirp pair has just completed.
- R12: Line-state inputs are decoded with priority single-ended-zero over J over K. No active input means an idle or other line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock, frequency set by CLK_FREQ_KHZ |
| rst_n | input | 1 | Synchronous active-low reset |
| line_se0 | input | 1 | Decoded line state is single-ended zero |
| line_j | input | 1 | Decoded line state is J |
| line_k | input | 1 | Decoded line state is K |
| squelch | input | 1 | High-speed squelch detector output |
| pullup_det | input | 1 | Pull-up detected on either data line |
| disconnect | input | 1 | Disconnect detected |
| fixture_det | input | 1 | Compliance test fixture detected |
| test_pkt_seen | input | 1 | Test-packet pattern observed |
| conn_det | output | 1 | Device connection detected |
| hs_en | output | 1 | Link is in High-speed operation |

## Verification
The bench targets the chirp window edges: lengths one cycle inside and one cycle outside both limits, for J and for K separately. A design with an off-by-one in its run counter, or with a window check that is exclusive where it should be inclusive, would accept or reject the wrong one of each pair. It also covers a reset that is one cycle too short, a J with no K, and a second chirp pair that arrives after a rejected one without a new bus reset. A tracker that does not fall back to waiting for reset would raise the flag on these sequences. Disconnect while in High-speed, a new bus reset while in High-speed, reset asserted partway through a handshake, and fixture or test-packet pulses arriving in the wrong state are each checked. These catch flags that stay set too long or that rise from the wrong state.

// File: rtl/usb_hs_mon_pkg.sv
// Package: shared types for the High-speed handshake monitor.
// Holds the decoded line symbol, the link-presence states and the chirp
// tracker states, plus the line decoder used by the top module.
package usb_hs_mon_pkg;

    // Decoded line symbol seen in one clock cycle.
    typedef enum logic [1:0] {
        SYM_OTHER = 2'd0,
        SYM_SE0   = 2'd1,
        SYM_J     = 2'd2,
        SYM_K     = 2'd3
    } line_sym_e;

    // Link-presence states.
    typedef enum logic [1:0] {
        LNK_UNCONN   = 2'd0,
        LNK_ATTACHED = 2'd1,
        LNK_FIXTURE  = 2'd2,
        LNK_FIX_HS   = 2'd3
    } link_state_e;

    // Chirp handshake tracker states.
    typedef enum logic [2:0] {
        HSK_WAIT_RESET = 3'd0,
        HSK_GOT_RESET  = 3'd1,
        HSK_IN_J       = 3'd2,
        HSK_IN_K       = 3'd3,
        HSK_WAIT_SQ    = 3'd4,
        HSK_HS_ACTIVE  = 3'd5
    } hsk_state_e;

    // Priority decode of the line-state inputs: SE0, then J, then K.
    function automatic line_sym_e decode_line(logic se0, logic j, logic k);
        if (se0)    return SYM_SE0;
        else if (j) return SYM_J;
        else if (k) return SYM_K;
        else        return SYM_OTHER;
    endfunction

endpackage

// File: rtl/usb_line_run_timer.sv
// Module: usb_line_run_timer
// Measures how long the decoded line symbol stays unchanged.
// When the symbol changes, it emits a one-cycle run_end pulse that
// carries the symbol that ended and its length in cycles. It also
// emits a reset_hit pulse in the cycle where an SE0 run reaches
// RESET_CYC. Assumes sym_in is synchronous to clk and RESET_CYC >= 2.
// The run length saturates at SAT_CYC, which is above every limit
// the tracker compares against.
module usb_line_run_timer
    import usb_hs_mon_pkg::*;
#(
    parameter int unsigned LEN_W     = 8,
    parameter int unsigned RESET_CYC = 3,
    parameter int unsigned SAT_CYC   = 129
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_sym_e        sym_in,
    output line_sym_e        cur_sym,
    output logic             run_end,
    output line_sym_e        ended_sym,
    output logic [LEN_W-1:0] ended_len,
    output logic             reset_hit
);

    localparam logic [LEN_W-1:0] ONE_L  = LEN_W'(1);
    localparam logic [LEN_W-1:0] SAT_L  = LEN_W'(SAT_CYC);
    localparam logic [LEN_W-1:0] RST_M1 = LEN_W'(RESET_CYC - 1);

    line_sym_e        cur_q;
    logic [LEN_W-1:0] len_q;
    logic             sym_change;

    assign sym_change = (sym_in != cur_q);

    // Track the current symbol and the length of its run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= SYM_OTHER;
            len_q <= '0;
        end else if (sym_change) begin
            cur_q <= sym_in;
            len_q <= ONE_L;
        end else if (len_q != SAT_L) begin
            len_q <= len_q + ONE_L;
        end
    end

    // Capture the run that just ended and flag long SE0 runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_end   <= 1'b0;
            ended_sym <= SYM_OTHER;
            ended_len <= '0;
            reset_hit <= 1'b0;
        end else begin
            run_end   <= sym_change;
            reset_hit <= (sym_in == SYM_SE0) && (cur_q == SYM_SE0) && (len_q == RST_M1);
            if (sym_change) begin
                ended_sym <= cur_q;
                ended_len <= len_q;
            end
        end
    end

    assign cur_sym = cur_q;

    AST_HIT_ON_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        reset_hit |-> (cur_sym == SYM_SE0)); // R4

    AST_END_CHANGES_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        run_end |-> (ended_sym != cur_sym)); // R12

endmodule

// File: rtl/usb_link_presence.sv
// Module: usb_link_presence
// Tracks whether anything is attached to the link. A pull-up or a
// compliance fixture is only accepted from the unconnected state, and
// the fixture takes priority when both are seen together. A test
// packet seen after a fixture raises the compliance High-speed
// indication. A disconnect always returns the link to unconnected.
module usb_link_presence
    import usb_hs_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pullup_det,
    input  logic disconnect,
    input  logic fixture_det,
    input  logic test_pkt_seen,
    output logic link_up,
    output logic attached,
    output logic fixture_hs
);

    link_state_e state_q;
    link_state_e state_d;

    // Next-state selection for the presence machine.
    always_comb begin
        state_d = state_q;
        if (disconnect) begin
            state_d = LNK_UNCONN;
        end else begin
            case (state_q)
                LNK_UNCONN: begin
                    if (fixture_det)     state_d = LNK_FIXTURE;
                    else if (pullup_det) state_d = LNK_ATTACHED;
                end
                LNK_FIXTURE: begin
                    if (test_pkt_seen)   state_d = LNK_FIX_HS;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State register for the presence machine.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LNK_UNCONN;
        else        state_q <= state_d;
    end

    assign link_up    = (state_q != LNK_UNCONN);
    assign attached   = (state_q == LNK_ATTACHED);
    assign fixture_hs = (state_q == LNK_FIX_HS);

    AST_CONN_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(pullup_det || fixture_det)); // R2

    AST_DISC_DROPS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        disconnect |=> !link_up); // R3

    AST_FIX_HS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fixture_hs) |-> $past(test_pkt_seen)); // R9

    AST_FIX_FROM_UNCONN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LNK_FIXTURE && $past(state_q) != LNK_FIXTURE)
            |-> ($past(state_q) == LNK_UNCONN)); // R10

endmodule

// File: rtl/usb_hs_chirp_tracker.sv
// Module: usb_hs_chirp_tracker
// Follows the High-speed detection sequence on an attached link: a bus
// reset, then one chirp J and one chirp K, each inside
// [MIN_CYC, MAX_CYC], then squelch. Any departure from that sequence
// sends it back to waiting for a bus reset. A new bus reset, a
// disconnect or loss of attachment clears the High-speed indication.
// Assumes the run events come from usb_line_run_timer.
module usb_hs_chirp_tracker
    import usb_hs_mon_pkg::*;
#(
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned MIN_CYC = 18,
    parameter int unsigned MAX_CYC = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_clear,
    input  logic             attached,
    input  logic             squelch,
    input  line_sym_e        cur_sym,
    input  logic             run_end,
    input  line_sym_e        ended_sym,
    input  logic [LEN_W-1:0] ended_len,
    input  logic             reset_hit,
    output logic             hs_active
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_CYC);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_CYC);

    hsk_state_e state_q;
    hsk_state_e state_d;
    logic       chirp_ok;

    // Chirp length check, inclusive at both limits.
    assign chirp_ok = (ended_len >= MIN_L) && (ended_len <= MAX_L);

    // Next-state selection for the handshake sequence.
    always_comb begin
        state_d = state_q;
        if (link_clear || !attached) begin
            state_d = HSK_WAIT_RESET;
        end else if (reset_hit) begin
            state_d = HSK_GOT_RESET;
        end else begin
            case (state_q)
                HSK_GOT_RESET: begin
                    if (run_end)
                        state_d = (ended_sym == SYM_SE0 && cur_sym == SYM_J)
                                  ? HSK_IN_J : HSK_WAIT_RESET;
                end
                HSK_IN_J: begin
                    if (run_end)
                        state_d = (ended_sym == SYM_J && chirp_ok && cur_sym == SYM_K)
                                  ? HSK_IN_K : HSK_WAIT_RESET;
                end
                HSK_IN_K: begin
                    if (run_end)
                        state_d = (ended_sym == SYM_K && chirp_ok)
                                  ? HSK_WAIT_SQ : HSK_WAIT_RESET;
                end
                HSK_WAIT_SQ: begin
                    if (squelch)
                        state_d = HSK_HS_ACTIVE;
                    else if (run_end && (cur_sym == SYM_J || cur_sym == SYM_K))
                        state_d = HSK_WAIT_RESET;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State register for the handshake sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HSK_WAIT_RESET;
        else        state_q <= state_d;
    end

    assign hs_active = (state_q == HSK_HS_ACTIVE);

    AST_HS_AFTER_SQUELCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_active) |-> $past(squelch)); // R5

    AST_BUS_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_hit |=> !hs_active); // R8

    AST_K_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HSK_WAIT_SQ && $past(state_q) == HSK_IN_K)
            |-> ($past(ended_len) >= MIN_L && $past(ended_len) <= MAX_L)); // R6

    AST_CLEAR_DROPS_HS: assert property (@(posedge clk) disable iff (!rst_n)
        link_clear |=> !hs_active); // R3

endmodule

// File: rtl/usb_hs_link_monitor.sv
// Module: usb_hs_link_monitor (top)
// Passive monitor that reports device attachment and High-speed entry
// for one USB 2.0 link. It converts the microsecond limits to cycle
// counts from CLK_FREQ_KHZ, decodes the line-state inputs, and combines
// the normal handshake path and the compliance-fixture path into
// hs_en. Assumes every input is synchronous to clk.
module usb_hs_link_monitor
    import usb_hs_mon_pkg::*;
#(
    parameter int unsigned CLK_FREQ_KHZ = 60000,
    parameter int unsigned CHIRP_MIN_US = 18,
    parameter int unsigned CHIRP_MAX_US = 128,
    parameter int unsigned RESET_MIN_US = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_se0,
    input  logic line_j,
    input  logic line_k,
    input  logic squelch,
    input  logic pullup_det,
    input  logic disconnect,
    input  logic fixture_det,
    input  logic test_pkt_seen,
    output logic conn_det,
    output logic hs_en
);

    localparam int unsigned MIN_CYC   = (CHIRP_MIN_US * CLK_FREQ_KHZ) / 1000;
    localparam int unsigned MAX_CYC   = (CHIRP_MAX_US * CLK_FREQ_KHZ) / 1000;
    localparam int unsigned RESET_CYC = (RESET_MIN_US * CLK_FREQ_KHZ) / 1000;
    localparam int unsigned SAT_CYC   = ((MAX_CYC > RESET_CYC) ? MAX_CYC : RESET_CYC) + 1;
    localparam int unsigned LEN_W     = $clog2(SAT_CYC + 1);

    line_sym_e        sym_now;
    line_sym_e        cur_sym;
    line_sym_e        ended_sym;
    logic             run_end;
    logic [LEN_W-1:0] ended_len;
    logic             reset_hit;
    logic             link_up;
    logic             attached;
    logic             fixture_hs;
    logic             hs_active;

    // Priority decode of the line-state inputs.
    always_comb begin
        sym_now = decode_line(line_se0, line_j, line_k);
    end

    usb_line_run_timer #(
        .LEN_W     (LEN_W),
        .RESET_CYC (RESET_CYC),
        .SAT_CYC   (SAT_CYC)
    ) u_run_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_in    (sym_now),
        .cur_sym   (cur_sym),
        .run_end   (run_end),
        .ended_sym (ended_sym),
        .ended_len (ended_len),
        .reset_hit (reset_hit)
    );

    usb_link_presence u_presence (
        .clk           (clk),
        .rst_n         (rst_n),
        .pullup_det    (pullup_det),
        .disconnect    (disconnect),
        .fixture_det   (fixture_det),
        .test_pkt_seen (test_pkt_seen),
        .link_up       (link_up),
        .attached      (attached),
        .fixture_hs    (fixture_hs)
    );

    usb_hs_chirp_tracker #(
        .LEN_W   (LEN_W),
        .MIN_CYC (MIN_CYC),
        .MAX_CYC (MAX_CYC)
    ) u_chirp (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_clear (disconnect),
        .attached   (attached),
        .squelch    (squelch),
        .cur_sym    (cur_sym),
        .run_end    (run_end),
        .ended_sym  (ended_sym),
        .ended_len  (ended_len),
        .reset_hit  (reset_hit),
        .hs_active  (hs_active)
    );

    assign conn_det = link_up;
    assign hs_en    = hs_active | fixture_hs;

    AST_HS_NEEDS_CONN: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> conn_det); // R3

endmodule

// File: tb/usb_hs_link_monitor_tb.sv
// Bench for usb_hs_link_monitor. The time base is scaled down
// (CLK_FREQ_KHZ = 1000) so that each chirp limit is a small cycle
// count: 18 and 128 cycles for the window, 3 cycles for a bus reset.
// Inputs change on the falling edge and outputs are sampled there.
`timescale 1ns/1ps
module usb_hs_link_monitor_tb;

    logic clk = 1'b0;
    logic rst_n, line_se0, line_j, line_k, squelch;
    logic pullup_det, disconnect, fixture_det, test_pkt_seen;
    logic conn_det, hs_en;
    int   checks   = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    usb_hs_link_monitor #(
        .CLK_FREQ_KHZ (1000),
        .CHIRP_MIN_US (18),
        .CHIRP_MAX_US (128),
        .RESET_MIN_US (3)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_se0      (line_se0),
        .line_j        (line_j),
        .line_k        (line_k),
        .squelch       (squelch),
        .pullup_det    (pullup_det),
        .disconnect    (disconnect),
        .fixture_det   (fixture_det),
        .test_pkt_seen (test_pkt_seen),
        .conn_det      (conn_det),
        .hs_en         (hs_en)
    );

    typedef struct packed {
        logic [15:0] se0_len;
        logic [15:0] j_len;
        logic [15:0] k_len;
        logic        exp_hs;
    } hs_vec_t;

    localparam int NVEC = 9;
    localparam hs_vec_t VECS [NVEC] = '{
        '{16'd5, 16'd18,  16'd18,  1'b1},  // R5 both chirps at lower limit
        '{16'd5, 16'd128, 16'd128, 1'b1},  // R5 both chirps at upper limit
        '{16'd5, 16'd17,  16'd40,  1'b0},  // R6 J one short
        '{16'd5, 16'd40,  16'd17,  1'b0},  // R6 K one short
        '{16'd5, 16'd129, 16'd40,  1'b0},  // R6 J one long
        '{16'd5, 16'd40,  16'd129, 1'b0},  // R6 K one long
        '{16'd2, 16'd40,  16'd40,  1'b0},  // R4 reset too short
        '{16'd3, 16'd40,  16'd40,  1'b1},  // R4 reset at minimum
        '{16'd5, 16'd40,  16'd0,   1'b0}   // R7 K missing
    };

    function automatic string vec_tag(int idx);
        case (idx)
            0, 1:       return "R5";
            2, 3, 4, 5: return "R6";
            6, 7:       return "R4";
            default:    return "R7";
        endcase
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_line(logic s, logic j, logic k);
        line_se0 = s;
        line_j   = j;
        line_k   = k;
    endtask

    task automatic fresh_attach();
        disconnect = 1'b1;
        step(1);
        disconnect = 1'b0;
        pullup_det = 1'b1;
        step(1);
        pullup_det = 1'b0;
        step(2);
    endtask

    task automatic idle_squelch();
        set_line(1'b0, 1'b0, 1'b0);
        squelch = 1'b1;
        step(4);
        squelch = 1'b0;
        step(1);
    endtask

    task automatic handshake(int se0_n, int j_n, int k_n);
        set_line(1'b1, 1'b0, 1'b0);
        step(se0_n);
        set_line(1'b0, 1'b1, 1'b0);
        step(j_n);
        if (k_n > 0) begin
            set_line(1'b0, 1'b0, 1'b1);
            step(k_n);
        end
        idle_squelch();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        set_line(1'b0, 1'b0, 1'b0);
        squelch = 1'b0; disconnect = 1'b0; fixture_det = 1'b0; test_pkt_seen = 1'b0;
        pullup_det = 1'b1;
        @(negedge clk);
        step(4);
        check("R1", "conn_det in reset", conn_det, 1'b0);
        check("R1", "hs_en in reset", hs_en, 1'b0);
        pullup_det = 1'b0;
        rst_n = 1'b1;
        step(2);
        check("R1", "conn_det after release", conn_det, 1'b0);

        pullup_det = 1'b1;
        step(1);
        pullup_det = 1'b0;
        check("R2", "conn_det after pull-up", conn_det, 1'b1);
        pullup_det = 1'b1;
        step(1);
        pullup_det = 1'b0;
        check("R2", "conn_det after second pull-up", conn_det, 1'b1);

        // Vector table walk: timed handshakes from a fresh attach.
        for (int i = 0; i < NVEC; i++) begin
            fresh_attach();
            check("R2", "conn_det before handshake", conn_det, 1'b1);
            handshake(int'(VECS[i].se0_len), int'(VECS[i].j_len), int'(VECS[i].k_len));
            check(vec_tag(i), $sformatf("hs_en vector %0d", i), hs_en, VECS[i].exp_hs);
        end

        // R8: a new bus reset clears hs_en until a fresh handshake.
        fresh_attach();
        handshake(5, 40, 40);
        check("R5", "hs_en after valid handshake", hs_en, 1'b1);
        set_line(1'b1, 1'b0, 1'b0);
        step(5);
        check("R8", "hs_en after new bus reset", hs_en, 1'b0);
        idle_squelch();
        check("R8", "hs_en stays clear after squelch", hs_en, 1'b0);
        handshake(5, 40, 40);
        check("R8", "hs_en after fresh handshake", hs_en, 1'b1);

        // R3: disconnect while in High-speed.
        disconnect = 1'b1;
        step(1);
        disconnect = 1'b0;
        check("R3", "conn_det after disconnect", conn_det, 1'b0);
        check("R3", "hs_en after disconnect", hs_en, 1'b0);
        step(3);
        check("R3", "conn_det stays low", conn_det, 1'b0);

        // R11: squelch with no handshake.
        fresh_attach();
        idle_squelch();
        check("R11", "hs_en after bare squelch", hs_en, 1'b0);

        // R7: a second chirp pair after a rejected one, with no new reset.
        fresh_attach();
        set_line(1'b1, 1'b0, 1'b0); step(5);
        set_line(1'b0, 1'b1, 1'b0); step(17);
        set_line(1'b0, 1'b0, 1'b1); step(40);
        set_line(1'b0, 1'b1, 1'b0); step(40);
        set_line(1'b0, 1'b0, 1'b1); step(40);
        idle_squelch();
        check("R7", "hs_en after pair without reset", hs_en, 1'b0);

        // R10: fixture and test packet while a device is attached.
        fresh_attach();
        fixture_det = 1'b1; step(1); fixture_det = 1'b0;
        test_pkt_seen = 1'b1; step(1); test_pkt_seen = 1'b0;
        step(1);
        check("R10", "hs_en after fixture while attached", hs_en, 1'b0);
        disconnect = 1'b1; step(1); disconnect = 1'b0;
        test_pkt_seen = 1'b1; step(1); test_pkt_seen = 1'b0;
        step(1);
        check("R10", "hs_en after test packet alone", hs_en, 1'b0);
        check("R10", "conn_det after test packet alone", conn_det, 1'b0);

        // R9: compliance fixture path, with fixture winning over pull-up.
        fixture_det = 1'b1; pullup_det = 1'b1;
        step(1);
        fixture_det = 1'b0; pullup_det = 1'b0;
        check("R9", "conn_det after fixture", conn_det, 1'b1);
        check("R9", "hs_en before test packet", hs_en, 1'b0);
        test_pkt_seen = 1'b1; step(1); test_pkt_seen = 1'b0;
        check("R9", "hs_en after test packet", hs_en, 1'b1);
        disconnect = 1'b1; step(1); disconnect = 1'b0;
        check("R3", "hs_en after fixture disconnect", hs_en, 1'b0);

        // R1: reset asserted in the middle of a handshake.
        fresh_attach();
        set_line(1'b1, 1'b0, 1'b0); step(5);
        set_line(1'b0, 1'b1, 1'b0); step(30);
        rst_n = 1'b0;
        step(3);
        check("R1", "conn_det during mid-handshake reset", conn_det, 1'b0);
        check("R1", "hs_en during mid-handshake reset", hs_en, 1'b0);
        rst_n = 1'b1;
        set_line(1'b0, 1'b0, 1'b1); step(30);
        idle_squelch();
        check("R1", "hs_en after interrupted handshake", hs_en, 1'b0);
        check("R1", "conn_det after interrupted handshake", conn_det, 1'b0);

        // R12: SE0 takes priority over J when both are driven.
        fresh_attach();
        set_line(1'b1, 1'b1, 1'b0); step(5);
        set_line(1'b0, 1'b1, 1'b1); step(40);
        set_line(1'b0, 1'b0, 1'b1); step(40);
        idle_squelch();
        check("R12", "hs_en with overlapping line inputs", hs_en, 1'b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule